// File: doc/BRIEF.md
# USB Host Controller Interrupt Unit

This block keeps the interrupt state of a USB 1.1 host controller and drives one level-sensitive interrupt request line. Single-cycle pulses from neighbouring logic (start of frame, done-queue writeback, root hub change and the rest) latch sticky status bits. Software sees three 32-bit word views on a simple register bus. The status view is cleared by writing ones. An enable-set view and an enable-clear view change the enable mask. The mask is never written directly.

The top bit of the enable mask is a master gate over every source. The request line is high only while the master gate is set and at least one latched status bit has its enable bit set. The line, the status register, the mask and the read data are all registered. The line always follows the state that is present after the same clock edge.

Top module: `usb_hc_irq_unit`

## Requirements
- R1: After a synchronous reset the status register reads 0x00000000, the enable mask reads 0x80000000 and irq_o is low.
- R2: Event input evt_i[k] maps to status bit k for k = 0 to 6 (0 scheduling overrun, 1 done-head writeback, 2 start of frame, 3 resume detect, 4 unrecoverable error, 5 frame number overflow, 6 root hub change). evt_i[7] (ownership change) maps to status bit 30.
- R3: An event pulse that is high at a clock edge sets its status bit at that edge. The bit stays set until software clears it.
- R4: A write to word index 0 (status view) clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to word index 1 (enable-set view) ORs the written value into the enable mask.
- R6: A write to word index 2 (enable-clear view) clears every enable bit written as 1.
- R7: A read is a cycle with bus_req high and bus_we low. bus_rdata shows the addressed view one clock after the read and holds that value until the next read. Word index 0 returns the status. Word indices 1 and 2 both return the enable mask.
- R8: irq_o is high exactly when enable bit 31 is set and the AND of status and enable is nonzero. It changes on the same clock edge as the status or enable change that causes it.
- R9: When an event pulse and a status-view clear of the same bit fall in the same cycle, the bit is left set.
- R10: Status bits other than 0 to 6 and 30 always read 0. Enable bits other than 0 to 6, 30 and 31 always read 0, even after a write of all ones to the enable-set view.
- R11: Reads of word indices 3 and above return 0. Writes to them change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the view |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_i | input | 8 | Single-cycle event pulses from the controller |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
Any wrong bit in the status register or the enable mask reaches irq_o at the first edge where that bit pairs with an enabled or latched partner under the master gate. It also shows on bus_rdata one cycle after the next read of the affected view. The bench compares both outputs against a behavioural model after every clock. A corrupted bit is therefore reported in the cycle where it first becomes visible at the ports, and is not left until the end of the run. Sticky status, same-cycle set and clear, and the unused bit positions each get their own stimulus. A fault that only shows when pulses and writes collide is still reached.

// File: rtl/irq_unit_pkg.sv
`timescale 1ns/1ps
package irq_unit_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_EVT = 8;
  localparam int MIE_POS = 31;
  localparam int OWN_POS = 30;

  // word indices of the register views
  localparam int VIEW_STATUS = 0;
  localparam int VIEW_EN_SET = 1;
  localparam int VIEW_EN_CLR = 2;

  // status bit position fed by event input k
  function automatic int evt_pos(input int k);
    return (k == NUM_EVT - 1) ? OWN_POS : k;
  endfunction

  function automatic logic [WORD_W-1:0] impl_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_EVT; k++) m[evt_pos(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] STS_MASK = impl_mask();
  localparam logic [WORD_W-1:0] MIE_MASK = WORD_W'(1) << MIE_POS;
  localparam logic [WORD_W-1:0] EN_MASK  = STS_MASK | MIE_MASK;
endpackage

// File: rtl/irq_evt_map.sv
`timescale 1ns/1ps
module irq_evt_map
  import irq_unit_pkg::*;
#(
  parameter int N_EVT = NUM_EVT
) (
  input  logic [N_EVT-1:0]  evt,
  output logic [WORD_W-1:0] set_vec
);
  always_comb begin
    set_vec = '0;
    for (int k = 0; k < N_EVT; k++) set_vec[evt_pos(k)] = evt[k];
  end
endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg
  import irq_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_vec,
  input  logic [WORD_W-1:0] clr_vec,
  output logic [WORD_W-1:0] sts_d,
  output logic [WORD_W-1:0] sts_q
);
  // a pulse wins over a same-cycle software clear
  always_comb sts_d = ((sts_q & ~clr_vec) | set_vec) & STS_MASK;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= sts_d;
  end
endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg
  import irq_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_vec,
  input  logic [WORD_W-1:0] clr_vec,
  output logic [WORD_W-1:0] en_d,
  output logic [WORD_W-1:0] en_q
);
  always_comb en_d = ((en_q & ~clr_vec) | set_vec) & EN_MASK;

  always_ff @(posedge clk) begin
    if (rst) en_q <= MIE_MASK;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/irq_line_drv.sv
`timescale 1ns/1ps
module irq_line_drv
  import irq_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] sts_d,
  input  logic [WORD_W-1:0] en_d,
  output logic              irq_q
);
  logic hit;
  always_comb hit = en_d[MIE_POS] & (|(sts_d & en_d));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end
endmodule

// File: rtl/usb_hc_irq_unit.sv
`timescale 1ns/1ps
module usb_hc_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(VIEW_STATUS);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(VIEW_EN_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(VIEW_EN_CLR);

  logic              wr, rd;
  logic [WORD_W-1:0] evt_set, sts_clr, en_set, en_clr;
  logic [WORD_W-1:0] sts_d, sts_q, en_d, en_q, rd_mux;

  always_comb begin
    wr      = bus_req & bus_we;
    rd      = bus_req & ~bus_we;
    sts_clr = (wr && bus_addr == A_STS) ? bus_wdata : '0;
    en_set  = (wr && bus_addr == A_SET) ? bus_wdata : '0;
    en_clr  = (wr && bus_addr == A_CLR) ? bus_wdata : '0;
  end

  irq_evt_map #(.N_EVT(NUM_EVT)) map_i (
    .evt     (evt_i),
    .set_vec (evt_set)
  );

  irq_status_reg sts_i (
    .clk     (clk),
    .rst     (rst),
    .set_vec (evt_set),
    .clr_vec (sts_clr),
    .sts_d   (sts_d),
    .sts_q   (sts_q)
  );

  irq_enable_reg en_i (
    .clk     (clk),
    .rst     (rst),
    .set_vec (en_set),
    .clr_vec (en_clr),
    .en_d    (en_d),
    .en_q    (en_q)
  );

  irq_line_drv line_i (
    .clk   (clk),
    .rst   (rst),
    .sts_d (sts_d),
    .en_d  (en_d),
    .irq_q (irq_o)
  );

  always_comb begin
    if (bus_addr == A_STS)                          rd_mux = sts_q;
    else if (bus_addr == A_SET || bus_addr == A_CLR) rd_mux = en_q;
    else                                            rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_unit_chk.sv
`timescale 1ns/1ps
module irq_unit_chk
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] evt_set,
  input logic [WORD_W-1:0] sts_q,
  input logic [WORD_W-1:0] en_q,
  input logic              irq_o
);
  logic rst_d;
  logic sts_wr, en_wr;
  always_comb begin
    sts_wr = bus_req & bus_we & (bus_addr == ADDR_W'(VIEW_STATUS));
    en_wr  = bus_req & bus_we &
             (bus_addr == ADDR_W'(VIEW_EN_SET) || bus_addr == ADDR_W'(VIEW_EN_CLR));
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_state_R1: assert (sts_q == '0 && en_q == MIE_MASK && !irq_o)
        else $error("reset state wrong");
    end
  end

  // R8
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (en_q[MIE_POS] && |(sts_q & en_q)));

  // R3 / R9: pulsed bits are set after the edge, even under a clear
  assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));

  // R3: sticky without clear
  assert_sts_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (!sts_wr && evt_set == '0) |=> $stable(sts_q));

  // R11 / R5 / R6: mask only moves through its two views
  assert_en_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(en_q));

  // R10
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ((sts_q & ~STS_MASK) == '0) && ((en_q & ~EN_MASK) == '0));
endmodule

bind usb_hc_irq_unit irq_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .evt_set  (evt_set),
  .sts_q    (sts_q),
  .en_q     (en_q),
  .irq_o    (irq_o)
);

// File: tb/usb_hc_irq_unit_tb_top.sv
`timescale 1ns/1ps
module usb_hc_irq_unit_tb_top;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [7:0]    evt_i = '0;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  bit [31:0] m_sts, m_en, m_rd;

  always #2 clk = ~clk;

  usb_hc_irq_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  function automatic bit [31:0] evt_bits(input bit [7:0] e);
    bit [31:0] v = 0;
    v[0] = e[0]; v[1] = e[1]; v[2] = e[2]; v[3] = e[3];
    v[4] = e[4]; v[5] = e[5]; v[6] = e[6]; v[30] = e[7];
    return v;
  endfunction

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, advance model, compare both outputs
  task automatic step(input string tag, input bit req, input bit we,
                      input int addr, input bit [31:0] wd, input bit [7:0] ev);
    bit [31:0] n_sts, n_en;
    bit        exp_irq;
    bus_req = req; bus_we = we; bus_addr = AW'(addr); bus_wdata = wd; evt_i = ev;
    n_sts = m_sts; n_en = m_en;
    if (req && !we) begin
      if (addr == 0) m_rd = m_sts;
      else if (addr == 1 || addr == 2) m_rd = m_en;
      else m_rd = 0;
    end
    if (req && we) begin
      if (addr == 0) n_sts = n_sts & ~wd;
      if (addr == 1) n_en = n_en | (wd & 32'hC000_007F);
      if (addr == 2) n_en = n_en & ~wd;
    end
    n_sts = n_sts | evt_bits(ev);
    m_sts = n_sts; m_en = n_en;
    exp_irq = m_en[31] && ((m_sts & m_en) != 0);
    @(posedge clk); #1;
    check({tag, " irq"}, {31'd0, irq_o}, {31'd0, exp_irq});
    check({tag, " rdata"}, bus_rdata, m_rd);
    bus_req = 0; evt_i = 0;
  endtask

  task automatic rd(input string tag, input int a);
    step(tag, 1, 0, a, 0, 0);
  endtask
  task automatic wr(input string tag, input int a, input bit [31:0] d);
    step(tag, 1, 1, a, d, 0);
  endtask
  task automatic idle(input string tag, input bit [7:0] ev);
    step(tag, 0, 0, 0, 0, ev);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_sts = 0; m_en = 32'h8000_0000; m_rd = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 0);
    check("R1 rdata", bus_rdata, 0);
    rd("R1 read enable", 1);
    rd("R1 read status", 0);

    // R2 / R3 / R4: each source lands at its position, then cleared
    for (int k = 0; k < 8; k++) begin
      idle("R2 pulse", 8'(1 << k));
      idle("R3 sticky", 0);
      rd("R2 read status", 0);
      wr("R4 clear", 0, evt_bits(8'(1 << k)));
      rd("R4 read cleared", 0);
    end

    // R4: zeros leave bits alone
    idle("R3 two pulses", 8'h05);
    wr("R4 zero write", 0, 32'h0000_0002);
    rd("R4 read kept", 0);

    // R5 / R8: enable start-of-frame, irq follows
    wr("R5 set sof", 1, 32'h0000_0004);
    rd("R7 read en-set view", 1);
    rd("R7 read en-clr view", 2);
    wr("R6 drop master", 2, 32'h8000_0000);
    idle("R8 gated", 0);
    wr("R5 master on", 1, 32'h8000_0000);
    wr("R4 clear sof", 0, 32'h0000_0004);
    wr("R4 clear rest", 0, 32'hFFFF_FFFF);
    idle("R8 pulse while enabled", 8'h04);
    idle("R8 hold", 0);

    // R9: same-cycle pulse and clear
    step("R9 pulse+clear", 1, 1, 0, 32'h0000_0004, 8'h04);
    rd("R9 read", 0);
    wr("R4 clear", 0, 32'h0000_0004);

    // R10: unused positions
    wr("R10 set all", 1, 32'hFFFF_FFFF);
    rd("R10 read en", 1);
    idle("R8 ownership", 8'h80);
    rd("R10 read sts", 0);
    wr("R6 clear all", 2, 32'h7FFF_FFFF);
    rd("R6 read en", 2);

    // R11: unmapped words
    wr("R11 write unmapped", 3, 32'hFFFF_FFFF);
    wr("R11 write unmapped hi", 15, 32'hFFFF_FFFF);
    rd("R11 read unmapped", 3);
    rd("R11 check sts", 0);
    rd("R11 check en", 1);
    idle("R7 rdata holds", 8'h7F);
    rd("R3 read all", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule